// File: doc/BRIEF.md
# Character-Sync Framer with Underrun Fill

This block handles the sync characters of a character-oriented synchronous serial channel, in both directions. The receive half takes one bit per strobe and searches the stream one bit position at a time for a programmed sync pattern. It declares character sync after one match in single-sync mode. In double-sync mode it needs two back-to-back matching characters. Once in sync it frames every following group of eight bits into a received character.

The transmit half serializes characters that arrive on a ready/valid input, one bit per strobe, least significant bit first. When the data source runs dry at a character boundary, the block sends a fill sequence chosen by a 2-bit selector. The sequence uses the two sync characters and, if selected, a check value that comes in on an input. After the sequence it keeps sending the second sync character until data is offered again. A message-length counter can also close a message by appending the check value after a programmed number of data characters. Line coding, buffering and the check computation itself are outside the block.

Top module: `csync_framer`

## Requirements
- R1: In single-sync mode (`cfg_double`=0), character sync is declared when the latest 8 received bits equal `cfg_sync1`. The first-received of those bits is bit 0. `rx_in_sync` rises one clock after the strobe that carried the completing bit, and not before that bit.
- R2: In double-sync mode (`cfg_double`=1), sync needs one character equal to `cfg_sync0` and then the very next 8 bits equal to `cfg_sync1`. A second character that differs sends the receiver back to bitwise search, and `cfg_sync1` on its own is not enough.
- R3: `rx_sync_pulse` is high for exactly one cycle each time sync is established. While in sync, every 8 received bits give one `rx_char_valid` cycle, with the character on `rx_char` (first-received bit in bit 0). No character is delivered outside sync.
- R4: A cycle with `rx_hunt` high drops sync on the next clock and restarts the bitwise search. Bits that arrive afterwards produce no characters until sync is found again.
- R5: Each `tx_bit_en` strobe advances the serial output by one bit, and the output holds between strobes. Characters are sent least significant bit first. The first strobe after reset starts a new character, and every 8 strobes after that start the next one.
- R6: A data character is taken only in a cycle where `tx_ready` and `tx_valid` are both high. `tx_ready` can be high only on the strobe that starts a character. A continuously offered stream is sent back to back with no fill between characters.
- R7: With no data at a boundary after a data character, `cfg_fill_sel` chooses the fill: 00 sends sync1; 01 sends sync0 then sync1; 10 sends check low, check high, then sync1; 11 sends check low, check high, sync0, then sync1. Offered data is not taken until the sequence has reached its sync1 character. `tx_fill` is 1 while a non-data character is being sent.
- R8: After the fill sequence, and from reset, the transmitter repeats `cfg_sync1`. Offered data is taken at the next character boundary.
- R9: `len_load` loads `len_value` into the message counter, and each data character taken decrements it. When a character takes it from 1 to 0, the check low and high bytes follow that character, and the transmitter then takes data or idles on sync1 regardless of `cfg_fill_sel`. A count of 0 disables this.
- R10: A check value goes out as two characters, `crc_in[7:0]` first and then `crc_in[15:8]`. Each byte is sampled at the boundary where that character starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_double | input | 1 | 1 selects double-sync receive mode |
| cfg_sync0 | input | 8 | First sync character |
| cfg_sync1 | input | 8 | Second sync character (single-mode and idle pattern) |
| cfg_fill_sel | input | 2 | Underrun fill sequence selector |
| rx_bit_valid | input | 1 | Receive bit strobe |
| rx_bit | input | 1 | Received serial bit |
| rx_hunt | input | 1 | Drop sync and restart search |
| rx_in_sync | output | 1 | Character sync held |
| rx_sync_pulse | output | 1 | One-cycle pulse when sync is established |
| rx_char_valid | output | 1 | Received character strobe |
| rx_char | output | 8 | Received character |
| tx_bit_en | input | 1 | Transmit bit strobe |
| tx_valid | input | 1 | Transmit data offered |
| tx_data | input | 8 | Transmit data character |
| tx_ready | output | 1 | Data is taken this cycle if valid |
| tx_bit | output | 1 | Transmit serial bit |
| tx_fill | output | 1 | Current transmit character is not data |
| crc_in | input | 16 | Check value supplied from outside |
| len_load | input | 1 | Load the message counter |
| len_value | input | 16 | Message length in characters |

## Verification
The assertions check on every cycle the local invariants: the sync pulse is one cycle long and coincides with sync, characters appear only in sync, hunt drops sync, a double-mode lock always passes through the second-character wait, ready appears only at a boundary, the check bytes come as a pair, and transmit state holds between strobes. The actual serial bit order, the correctness of each fill sequence, resumption after fill, message-length closing and the rejection of near-miss bit patterns depend on whole sequences of characters. Only the bench scenarios can show those, by reassembling the serial output and replaying chosen bit streams.

// File: rtl/csf_pkg.sv
package csf_pkg;
   typedef enum logic [1:0] {
      RX_HUNT   = 2'd0,
      RX_SECOND = 2'd1,
      RX_LOCKED = 2'd2
   } rx_state_e;

   typedef enum logic [2:0] {
      TK_IDLE   = 3'd0,
      TK_DATA   = 3'd1,
      TK_CRC_LO = 3'd2,
      TK_CRC_HI = 3'd3,
      TK_SYN0   = 3'd4
   } tx_kind_e;

   localparam logic [1:0] FILL_S1       = 2'b00;
   localparam logic [1:0] FILL_S0_S1    = 2'b01;
   localparam logic [1:0] FILL_C_S1     = 2'b10;
   localparam logic [1:0] FILL_C_S0_S1  = 2'b11;
endpackage

// File: rtl/csf_rx_hunter.sv
module csf_rx_hunter
   import csf_pkg::*;
#(
   parameter int CHAR_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_double,
   input  logic [CHAR_W-1:0] sync0,
   input  logic [CHAR_W-1:0] sync1,
   input  logic              bit_valid,
   input  logic              bit_in,
   input  logic              hunt,
   output logic              in_sync,
   output logic              sync_pulse,
   output logic              char_valid,
   output logic [CHAR_W-1:0] char_out
);
   localparam int CNT_W = $clog2(CHAR_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W - 1);

   rx_state_e         state;
   logic [CHAR_W-1:0] sr, sr_nx;
   logic [CNT_W-1:0]  cnt;
   logic              last_bit;
   logic [CHAR_W-1:0] first_pat;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign sr_nx = {bit_in, sr[CHAR_W-1:1]};
      end else begin : g_msb
         assign sr_nx = {sr[CHAR_W-2:0], bit_in};
      end
   endgenerate

   assign last_bit  = (cnt == LAST);
   assign first_pat = cfg_double ? sync0 : sync1;
   assign in_sync   = (state == RX_LOCKED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= RX_HUNT;
         sr         <= '0;
         cnt        <= '0;
         sync_pulse <= 1'b0;
         char_valid <= 1'b0;
         char_out   <= '0;
      end else begin
         sync_pulse <= 1'b0;
         char_valid <= 1'b0;
         if (hunt) begin
            state <= RX_HUNT;
            cnt   <= '0;
         end else if (bit_valid) begin
            sr <= sr_nx;
            unique case (state)
               RX_HUNT: begin
                  if (sr_nx == first_pat) begin
                     cnt <= '0;
                     if (cfg_double) begin
                        state <= RX_SECOND;
                     end else begin
                        state      <= RX_LOCKED;
                        sync_pulse <= 1'b1;
                     end
                  end
               end
               RX_SECOND: begin
                  if (last_bit) begin
                     cnt <= '0;
                     if (sr_nx == sync1) begin
                        state      <= RX_LOCKED;
                        sync_pulse <= 1'b1;
                     end else begin
                        state <= RX_HUNT;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_LOCKED: begin
                  if (last_bit) begin
                     cnt        <= '0;
                     char_valid <= 1'b1;
                     char_out   <= sr_nx;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= RX_HUNT;
            endcase
         end
      end
   end

   // R1: without a bit or a hunt the receiver state does not move
   assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_valid && !hunt |=> $stable(state) && $stable(cnt));
   // R2: a double-mode lock always comes out of the second-character wait
   assert_double_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_sync) && $past(cfg_double) |-> $past(state) == RX_SECOND);
   // R3
   assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sync_pulse |=> !sync_pulse);
   assert_pulse_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sync_pulse |-> in_sync);
   assert_char_in_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
      char_valid |-> in_sync);
   // R4
   assert_hunt_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hunt |=> !in_sync && !sync_pulse && !char_valid);
endmodule

// File: rtl/csf_tx_seq.sv
module csf_tx_seq
   import csf_pkg::*;
#(
   parameter int CHAR_W = 8,
   parameter int LEN_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          fill_sel,
   input  logic                boundary,
   input  logic                tx_valid,
   input  logic [CHAR_W-1:0]   tx_data,
   input  logic [2*CHAR_W-1:0] crc_in,
   input  logic [CHAR_W-1:0]   sync0,
   input  logic [CHAR_W-1:0]   sync1,
   input  logic                len_load,
   input  logic [LEN_W-1:0]    len_value,
   output logic                tx_ready,
   output logic [CHAR_W-1:0]   next_char,
   output logic                fill_now
);
   tx_kind_e         kind, nk;
   logic             crc_by_len;
   logic             len_hit;
   logic [LEN_W-1:0] len_cnt;
   logic             ready_kind;
   logic             take;

   assign ready_kind = (kind == TK_IDLE) ||
                       (kind == TK_DATA && !len_hit) ||
                       (kind == TK_CRC_HI && crc_by_len);
   assign tx_ready   = boundary && ready_kind;
   assign take       = tx_ready && tx_valid;
   assign fill_now   = (kind != TK_DATA);

   always_comb begin
      nk = TK_IDLE;
      unique case (kind)
         TK_IDLE:   nk = take ? TK_DATA : TK_IDLE;
         TK_DATA: begin
            if (len_hit)   nk = TK_CRC_LO;
            else if (take) nk = TK_DATA;
            else begin
               unique case (fill_sel)
                  FILL_S1:    nk = TK_IDLE;
                  FILL_S0_S1: nk = TK_SYN0;
                  default:    nk = TK_CRC_LO;
               endcase
            end
         end
         TK_CRC_LO: nk = TK_CRC_HI;
         TK_CRC_HI: begin
            if (crc_by_len) nk = take ? TK_DATA : TK_IDLE;
            else            nk = fill_sel[0] ? TK_SYN0 : TK_IDLE;
         end
         TK_SYN0:   nk = TK_IDLE;
         default:   nk = TK_IDLE;
      endcase
   end

   always_comb begin
      unique case (nk)
         TK_DATA:   next_char = tx_data;
         TK_CRC_LO: next_char = crc_in[CHAR_W-1:0];
         TK_CRC_HI: next_char = crc_in[2*CHAR_W-1:CHAR_W];
         TK_SYN0:   next_char = sync0;
         default:   next_char = sync1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind       <= TK_IDLE;
         crc_by_len <= 1'b0;
         len_hit    <= 1'b0;
         len_cnt    <= '0;
      end else begin
         if (boundary) begin
            kind    <= nk;
            len_hit <= take && (len_cnt == LEN_W'(1));
            if (kind == TK_DATA) crc_by_len <= len_hit;
         end
         if (len_load)                     len_cnt <= len_value;
         else if (take && len_cnt != '0)   len_cnt <= len_cnt - 1'b1;
      end
   end

   // R5: nothing advances between strobes
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary && !len_load |=> $stable(kind) && $stable(len_cnt) && $stable(len_hit));
   // R6
   assert_ready_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> boundary);
   // R7: sync0 in a fill is always followed by sync1
   assert_syn0_then_syn1_R7: assert property (@(posedge clk) disable iff (!rst_n)
      boundary && kind == TK_SYN0 |=> kind == TK_IDLE);
   // R9
   assert_len_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
      boundary && len_hit |=> kind == TK_CRC_LO);
   // R10
   assert_crc_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
      boundary && kind == TK_CRC_LO |=> kind == TK_CRC_HI);
endmodule

// File: rtl/csf_tx_shifter.sv
module csf_tx_shifter #(
   parameter int CHAR_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [CHAR_W-1:0] next_char,
   output logic              boundary,
   output logic              tx_bit
);
   localparam int CNT_W = $clog2(CHAR_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W - 1);

   logic [CHAR_W-1:0] cur;
   logic [CNT_W-1:0]  idx;

   assign boundary = bit_en && (idx == LAST);

   generate
      if (LSB_FIRST) begin : g_lsb
         assign tx_bit = cur[idx];
      end else begin : g_msb
         assign tx_bit = cur[LAST - idx];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur <= '0;
         idx <= LAST;
      end else if (bit_en) begin
         if (idx == LAST) begin
            idx <= '0;
            cur <= next_char;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   // R5
   assert_idx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(idx) && $stable(cur));
   assert_char_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      boundary |=> idx == '0);
endmodule

// File: rtl/csync_framer.sv
module csync_framer
   import csf_pkg::*;
#(
   parameter int CHAR_W    = 8,
   parameter int LEN_W     = 16,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_double,
   input  logic [CHAR_W-1:0]   cfg_sync0,
   input  logic [CHAR_W-1:0]   cfg_sync1,
   input  logic [1:0]          cfg_fill_sel,
   input  logic                rx_bit_valid,
   input  logic                rx_bit,
   input  logic                rx_hunt,
   output logic                rx_in_sync,
   output logic                rx_sync_pulse,
   output logic                rx_char_valid,
   output logic [CHAR_W-1:0]   rx_char,
   input  logic                tx_bit_en,
   input  logic                tx_valid,
   input  logic [CHAR_W-1:0]   tx_data,
   output logic                tx_ready,
   output logic                tx_bit,
   output logic                tx_fill,
   input  logic [2*CHAR_W-1:0] crc_in,
   input  logic                len_load,
   input  logic [LEN_W-1:0]    len_value
);
   generate
      if (CHAR_W < 4) begin : g_bad_char
         $error("csync_framer: CHAR_W must be at least 4");
      end
      if (LEN_W < 2) begin : g_bad_len
         $error("csync_framer: LEN_W must be at least 2");
      end
   endgenerate

   logic              boundary;
   logic [CHAR_W-1:0] next_char;

   csf_rx_hunter #(.CHAR_W(CHAR_W), .LSB_FIRST(LSB_FIRST)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_double (cfg_double),
      .sync0      (cfg_sync0),
      .sync1      (cfg_sync1),
      .bit_valid  (rx_bit_valid),
      .bit_in     (rx_bit),
      .hunt       (rx_hunt),
      .in_sync    (rx_in_sync),
      .sync_pulse (rx_sync_pulse),
      .char_valid (rx_char_valid),
      .char_out   (rx_char)
   );

   csf_tx_seq #(.CHAR_W(CHAR_W), .LEN_W(LEN_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill_sel  (cfg_fill_sel),
      .boundary  (boundary),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .crc_in    (crc_in),
      .sync0     (cfg_sync0),
      .sync1     (cfg_sync1),
      .len_load  (len_load),
      .len_value (len_value),
      .tx_ready  (tx_ready),
      .next_char (next_char),
      .fill_now  (tx_fill)
   );

   csf_tx_shifter #(.CHAR_W(CHAR_W), .LSB_FIRST(LSB_FIRST)) u_shf (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (tx_bit_en),
      .next_char (next_char),
      .boundary  (boundary),
      .tx_bit    (tx_bit)
   );
endmodule

// File: tb/csync_framer_tb.sv
module csync_framer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_double = 1'b0;
   logic [7:0]  cfg_sync0 = 8'h32;
   logic [7:0]  cfg_sync1 = 8'h16;
   logic [1:0]  cfg_fill_sel = 2'b00;
   logic        rx_bit_valid = 1'b0, rx_bit = 1'b0, rx_hunt = 1'b0;
   logic        rx_in_sync, rx_sync_pulse, rx_char_valid;
   logic [7:0]  rx_char;
   logic        tx_bit_en = 1'b0, tx_valid = 1'b0;
   logic [7:0]  tx_data = 8'h00;
   logic        tx_ready, tx_bit, tx_fill;
   logic [15:0] crc_in = 16'hBEEF;
   logic        len_load = 1'b0;
   logic [15:0] len_value = 16'h0;

   int n_tests = 0, n_fail = 0;
   int pulse_cnt = 0, char_cnt = 0;
   logic [7:0] last_char = 8'h00;

   always #2 clk = ~clk;

   csync_framer u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_double(cfg_double), .cfg_sync0(cfg_sync0),
      .cfg_sync1(cfg_sync1), .cfg_fill_sel(cfg_fill_sel), .rx_bit_valid(rx_bit_valid),
      .rx_bit(rx_bit), .rx_hunt(rx_hunt), .rx_in_sync(rx_in_sync),
      .rx_sync_pulse(rx_sync_pulse), .rx_char_valid(rx_char_valid), .rx_char(rx_char),
      .tx_bit_en(tx_bit_en), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .tx_bit(tx_bit), .tx_fill(tx_fill), .crc_in(crc_in), .len_load(len_load),
      .len_value(len_value)
   );

   always @(posedge clk) begin
      #1;
      if (rx_sync_pulse) pulse_cnt++;
      if (rx_char_valid) begin
         char_cnt++;
         last_char = rx_char;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one transmit character time: 8 strobes, reassembled LSB first
   task automatic tx_step(input logic v, input logic [7:0] d,
                          output logic [7:0] ch, output logic acc);
      tx_valid = v; tx_data = d; tx_bit_en = 1'b1;
      #1;
      acc = tx_ready && v;
      @(posedge clk); @(negedge clk);
      ch[0] = tx_bit;
      tx_valid = 1'b0;
      for (int i = 1; i < 8; i++) begin
         @(posedge clk); @(negedge clk);
         ch[i] = tx_bit;
      end
      tx_bit_en = 1'b0;
   endtask

   task automatic tx_expect(input string req, input logic v, input logic [7:0] d,
                            input logic [7:0] exp_ch, input logic exp_acc);
      logic [7:0] ch;
      logic acc;
      tx_step(v, d, ch, acc);
      check(req, {24'h0, ch}, {24'h0, exp_ch});
      check(req, {31'h0, acc}, {31'h0, exp_acc});
   endtask

   task automatic rx_send(input logic [7:0] b, input int first, input int n);
      for (int i = first; i < first + n; i++) begin
         rx_bit_valid = 1'b1; rx_bit = b[i];
         @(posedge clk); @(negedge clk);
      end
      rx_bit_valid = 1'b0;
   endtask

   task automatic t_reset;
      check("R3 reset sync", {31'h0, rx_in_sync}, 0);
      check("R3 reset pulse", {31'h0, rx_sync_pulse}, 0);
      check("R3 reset char", {31'h0, rx_char_valid}, 0);
      check("R6 reset ready", {31'h0, tx_ready}, 0);
   endtask

   task automatic t_tx_idle;
      tx_expect("R8 idle after reset", 1'b0, 8'h00, 8'h16, 1'b0);
      check("R7 fill flag idle", {31'h0, tx_fill}, 1);
      tx_expect("R8 idle repeat", 1'b0, 8'h00, 8'h16, 1'b0);
   endtask

   task automatic t_tx_data_fill00;
      cfg_fill_sel = 2'b00;
      tx_expect("R5 R6 first data", 1'b1, 8'hA5, 8'hA5, 1'b1);
      check("R7 fill flag data", {31'h0, tx_fill}, 0);
      tx_expect("R6 back to back", 1'b1, 8'h3C, 8'h3C, 1'b1);
      tx_expect("R7 fill 00", 1'b0, 8'h00, 8'h16, 1'b0);
      tx_expect("R8 resume", 1'b1, 8'h81, 8'h81, 1'b1);
   endtask

   task automatic t_tx_fill01;
      cfg_fill_sel = 2'b01;
      tx_expect("R7 fill 01 syn0", 1'b0, 8'h00, 8'h32, 1'b0);
      tx_expect("R7 fill 01 syn1 no take", 1'b1, 8'h44, 8'h16, 1'b0);
      tx_expect("R8 resume after 01", 1'b1, 8'h44, 8'h44, 1'b1);
   endtask

   task automatic t_tx_fill10;
      cfg_fill_sel = 2'b10;
      tx_expect("R10 fill 10 crc lo", 1'b0, 8'h00, 8'hEF, 1'b0);
      tx_expect("R10 fill 10 crc hi", 1'b0, 8'h00, 8'hBE, 1'b0);
      tx_expect("R7 fill 10 syn1", 1'b0, 8'h00, 8'h16, 1'b0);
      tx_expect("R8 resume after 10", 1'b1, 8'h99, 8'h99, 1'b1);
   endtask

   task automatic t_tx_fill11;
      cfg_fill_sel = 2'b11;
      tx_expect("R7 fill 11 crc lo", 1'b0, 8'h00, 8'hEF, 1'b0);
      tx_expect("R7 fill 11 crc hi no take", 1'b1, 8'h11, 8'hBE, 1'b0);
      tx_expect("R7 fill 11 syn0 no take", 1'b1, 8'h11, 8'h32, 1'b0);
      tx_expect("R7 fill 11 syn1 no take", 1'b1, 8'h11, 8'h16, 1'b0);
      tx_expect("R8 resume after 11", 1'b1, 8'h5C, 8'h5C, 1'b1);
   endtask

   task automatic t_tx_length;
      cfg_fill_sel = 2'b11;
      len_value = 16'd2; len_load = 1'b1;
      @(posedge clk); @(negedge clk);
      len_load = 1'b0;
      tx_expect("R9 msg char 1", 1'b1, 8'hC1, 8'hC1, 1'b1);
      tx_expect("R9 msg char 2", 1'b1, 8'hC2, 8'hC2, 1'b1);
      tx_expect("R9 R10 len crc lo", 1'b1, 8'hC3, 8'hEF, 1'b0);
      tx_expect("R9 R10 len crc hi", 1'b1, 8'hC3, 8'hBE, 1'b0);
      tx_expect("R9 data right after len crc", 1'b1, 8'hC3, 8'hC3, 1'b1);
      tx_expect("R9 counter spent", 1'b1, 8'hC4, 8'hC4, 1'b1);
   endtask

   task automatic t_rx_single;
      cfg_double = 1'b0;
      rx_send(8'h05, 0, 3);
      rx_send(8'h16, 0, 7);
      check("R1 no early sync", {31'h0, rx_in_sync}, 0);
      rx_send(8'h16, 7, 1);
      check("R1 single sync", {31'h0, rx_in_sync}, 1);
      check("R3 one pulse", pulse_cnt, 1);
      rx_send(8'h5A, 0, 8);
      check("R3 char count", char_cnt, 1);
      check("R3 char value", {24'h0, last_char}, 32'h5A);
      rx_send(8'hC3, 0, 8);
      check("R3 no repeat pulse", pulse_cnt, 1);
      check("R3 second char", {24'h0, last_char}, 32'hC3);
   endtask

   task automatic t_rx_hunt;
      rx_hunt = 1'b1;
      @(posedge clk); @(negedge clk);
      rx_hunt = 1'b0;
      check("R4 hunt drops sync", {31'h0, rx_in_sync}, 0);
      rx_send(8'h5A, 0, 8);
      check("R4 no chars in hunt", char_cnt, 2);
      check("R4 still hunting", {31'h0, rx_in_sync}, 0);
   endtask

   task automatic t_rx_double;
      cfg_double = 1'b1;
      rx_send(8'h16, 0, 8);
      check("R2 sync1 alone", {31'h0, rx_in_sync}, 0);
      rx_send(8'h32, 0, 8);
      rx_send(8'h77, 0, 8);
      check("R2 bad second char", {31'h0, rx_in_sync}, 0);
      check("R2 no pulse on miss", pulse_cnt, 1);
      rx_send(8'h32, 0, 8);
      check("R2 first only", {31'h0, rx_in_sync}, 0);
      rx_send(8'h16, 0, 8);
      check("R2 double sync", {31'h0, rx_in_sync}, 1);
      check("R3 pulse on double", pulse_cnt, 2);
      rx_send(8'hE7, 0, 8);
      check("R3 char after double", {24'h0, last_char}, 32'hE7);
      check("R3 char count double", char_cnt, 3);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_tx_idle;
      t_tx_data_fill00;
      t_tx_fill01;
      t_tx_fill10;
      t_tx_fill11;
      t_tx_length;
      t_rx_single;
      t_rx_hunt;
      t_rx_double;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule